// File: doc/BRIEF.md
# Multi-Rate Serial Channel Receiver

This block takes one serial time-division input line and turns it into a sequence of channel bytes for a downstream data memory. All timing comes from a shared 16.384 MHz clock enable (`tick_16m`, one system-clock cycle wide) and a shared frame pulse. A 2-bit rate code sets the line rate to 2.048, 4.096, 8.192 or 16.384 Mb/s. The receiver samples the line on every 8th, 4th, 2nd or every tick, in step with the frame pulse. A frame always lasts 2048 ticks, so the channel count follows the rate: 32, 64, 128 or 256 channels.

Board skew is absorbed by moving the stream's own frame start. A bit delay (0 to 7 bit periods) and a channel delay (0 to 3 channels) add up to a start offset of `chan_delay*8 + bit_delay` bit periods after the frame pulse. Bits are packed into bytes with the first bit received in the most significant position. Each finished byte is presented with its channel index for one clock. Subrate traffic (1-, 2- or 4-bit fields of a slower line) is captured by programming a faster rate than the line runs at. Each slow bit then shows up replicated across the byte.

The output is a stream with a valid flag only. A serial line cannot be paused, so there is no ready input and no back-pressure. The consumer must accept every byte in the cycle it is flagged, for example as a write strobe into a memory. Control inputs are plain levels.

Top module: `serial_stream_rx`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a stream start has taken place. A stream start needs `frame_pulse` high in a cycle where `tick_16m` is high.
- R2: Rate code 0/1/2/3 selects 2.048/4.096/8.192/16.384 Mb/s. The line is sampled on every 8th/4th/2nd/every tick, counted from the stream start. The channel count is 32/64/128/256.
- R3: The eight samples of a channel are packed most significant bit first: the first sample lands in `out_data[7]` and the last in `out_data[0]`.
- R4: `out_valid` is high for exactly one cycle, the cycle after the clock edge that samples the eighth bit of a channel. `out_chan` and `out_data` carry that channel's index and byte in the same cycle.
- R5: The channel index starts at 0 at each stream start, counts up by one per byte, and wraps to 0 after the last channel of the active rate.
- R6: With both delays zero, the tick that carries the frame pulse is the stream start: it samples bit 7 of channel 0.
- R7: A bit delay of b moves the stream start b bit periods of the active rate past the frame-pulse tick.
- R8: A channel delay of c moves the stream start a further 8*c bit periods, so the total offset is (8*c + b) bit periods.
- R9: The rate code and both delays are read at the frame-pulse tick. The rate takes effect at the stream start that follows. A change in mid-frame does not alter the bytes of the frame in progress.
- R10: With rate code 3 on a line running at 2.048 Mb/s, each output byte is 8'h00 or 8'hFF, holding one line bit per byte.
- R11: A stream start resets the bit position and channel index. A partial byte cut short by a start produces no output, and the next byte is channel 0 aligned to the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16m | input | 1 | 16.384 MHz clock enable, one cycle wide |
| frame_pulse | input | 1 | Frame reference, qualified by `tick_16m` |
| rate_sel | input | 2 | Line rate code (0..3) |
| bit_delay | input | 3 | Start offset in bit periods |
| chan_delay | input | 2 | Start offset in whole channels |
| serial_in | input | 1 | Serial line |
| out_valid | output | 1 | Byte strobe, one cycle |
| out_chan | output | 8 | Channel index of the byte |
| out_data | output | 8 | Assembled channel byte |

## Verification
The assertions rely on a few properties of the inputs. `tick_16m` is a single-cycle enable. `frame_pulse` means something only when qualified by a tick. The active rate moves only at a stream start, the checker's picture of a stream start comes from the internal start signal, and no byte appears before the first start. The stimulus stays within these limits. It raises the tick on every other clock and the frame pulse only on tick cycles, every 2048 ticks. The serial line changes only on tick cycles, and rate or delay codes change only at mid-frame, so the next frame pulse picks up the new values.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

  localparam int PH_W    = 3;   // phase counter width, covers divide-by-8
  localparam int RATE_W  = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_16M = 2'd3
  } rate_e;

  // ticks per bit minus one, used as a wrap mask for the phase counter
  function automatic logic [PH_W-1:0] div_mask(rate_e r);
    case (r)
      RATE_2M:  return 3'd7;
      RATE_4M:  return 3'd3;
      RATE_8M:  return 3'd1;
      default:  return 3'd0;
    endcase
  endfunction

  // index of the final channel in a frame
  function automatic logic [7:0] chan_last(rate_e r);
    case (r)
      RATE_2M:  return 8'd31;
      RATE_4M:  return 8'd63;
      RATE_8M:  return 8'd127;
      default:  return 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/ssrx_align.sv
module ssrx_align
  import ssrx_pkg::*;
#(
  parameter int BD_W = 3,
  parameter int CD_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            frame_pulse,
  input  rate_e           rate_sel,
  input  logic [BD_W-1:0] bit_dly,
  input  logic [CD_W-1:0] chan_dly,
  output logic            start,
  output rate_e           start_rate
);
  localparam int OFF_W = BD_W + CD_W + PH_W;

  logic             fp_hit;
  logic [OFF_W-1:0] dly_bits;
  logic [OFF_W-1:0] off_ticks;
  logic [OFF_W-1:0] cnt;
  logic             armed;
  rate_e            rate_pend;

  always_comb begin
    fp_hit   = tick & frame_pulse;
    dly_bits = (OFF_W'(chan_dly) << BD_W) | OFF_W'(bit_dly);
    case (rate_sel)
      RATE_2M:  off_ticks = dly_bits << 3;
      RATE_4M:  off_ticks = dly_bits << 2;
      RATE_8M:  off_ticks = dly_bits << 1;
      default:  off_ticks = dly_bits;
    endcase
    start      = (fp_hit & (off_ticks == '0)) |
                 (tick & ~fp_hit & armed & (cnt == OFF_W'(1)));
    start_rate = fp_hit ? rate_sel : rate_pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt       <= '0;
      rate_pend <= RATE_2M;
    end else if (fp_hit) begin
      armed     <= (off_ticks != '0);
      cnt       <= off_ticks;
      rate_pend <= rate_sel;
    end else if (tick && armed) begin
      cnt <= cnt - OFF_W'(1);
      if (cnt == OFF_W'(1)) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/ssrx_pace.sv
module ssrx_pace
  import ssrx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  start,
  input  rate_e start_rate,
  output rate_e act_rate,
  output logic  sample_en
);
  logic [PH_W-1:0] phase;
  logic            running;

  always_comb sample_en = tick & (start | (running & (phase == '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_rate <= RATE_2M;
      phase    <= '0;
      running  <= 1'b0;
    end else if (start) begin
      act_rate <= start_rate;
      running  <= 1'b1;
      phase    <= PH_W'(1) & div_mask(start_rate);
    end else if (tick && running) begin
      phase <= (phase + PH_W'(1)) & div_mask(act_rate);
    end
  end

endmodule

// File: rtl/ssrx_pack.sv
module ssrx_pack
  import ssrx_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              start,
  input  logic              serial_in,
  input  rate_e             act_rate,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [BYTE_W-1:0] out_data
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] shreg;
  logic [BC_W-1:0]   bitc;
  logic [CH_W-1:0]   chan;
  logic [BC_W-1:0]   bit_idx;
  logic [CH_W-1:0]   cur_chan;
  logic [CH_W-1:0]   next_chan;
  logic              last_bit;

  always_comb begin
    bit_idx   = start ? '0 : bitc;
    cur_chan  = start ? '0 : chan;
    last_bit  = (bit_idx == BC_W'(BYTE_W - 1));
    next_chan = (cur_chan == CH_W'(chan_last(act_rate))) ? '0 : cur_chan + CH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bitc      <= '0;
      chan      <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (sample_en) begin
        shreg <= {shreg[BYTE_W-3:0], serial_in};
        bitc  <= bit_idx + BC_W'(1);
        chan  <= last_bit ? next_chan : cur_chan;
        if (last_bit) begin
          out_valid <= 1'b1;
          out_chan  <= cur_chan;
          out_data  <= {shreg, serial_in};
        end
      end
    end
  end

endmodule

// File: rtl/serial_stream_rx.sv
module serial_stream_rx
  import ssrx_pkg::*;
#(
  parameter int BD_W   = 3,
  parameter int CD_W   = 2,
  parameter int CH_W   = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16m,
  input  logic              frame_pulse,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [BD_W-1:0]   bit_delay,
  input  logic [CD_W-1:0]   chan_delay,
  input  logic              serial_in,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [BYTE_W-1:0] out_data
);
  logic  start_w;
  rate_e start_rate_w;
  rate_e act_rate_w;
  logic  sample_w;

  ssrx_align #(.BD_W(BD_W), .CD_W(CD_W)) u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_16m),
    .frame_pulse (frame_pulse),
    .rate_sel    (rate_e'(rate_sel)),
    .bit_dly     (bit_delay),
    .chan_dly    (chan_delay),
    .start       (start_w),
    .start_rate  (start_rate_w)
  );

  ssrx_pace u_pace (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_16m),
    .start      (start_w),
    .start_rate (start_rate_w),
    .act_rate   (act_rate_w),
    .sample_en  (sample_w)
  );

  ssrx_pack #(.CH_W(CH_W), .BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_w),
    .start     (start_w),
    .serial_in (serial_in),
    .act_rate  (act_rate_w),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

endmodule

// File: rtl/ssrx_chk.sv
module ssrx_chk #(
  parameter int CH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            start,
  input logic            sample_en,
  input logic [1:0]      act_rate,
  input logic            out_valid,
  input logic [CH_W-1:0] out_chan
);
  logic seen_start;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_start <= 1'b0;
    else if (start) seen_start <= 1'b1;
  end

  // R1: no byte before the first stream start
  assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen_start);

  // R2: sampling only ever happens on a tick
  assert_sample_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> tick);

  // R4: strobe lasts a single cycle
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: channel index below the active channel count
  assert_chan_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_chan) < (32 << act_rate)));

  // R9: active rate moves only right after a stream start
  assert_rate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_rate) |-> $past(start));

endmodule

bind serial_stream_rx ssrx_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_16m),
  .start     (start_w),
  .sample_en (sample_w),
  .act_rate  (act_rate_w),
  .out_valid (out_valid),
  .out_chan  (out_chan)
);

// File: tb/test_serial_stream_rx.sv
module test_serial_stream_rx;

  typedef struct packed {
    int unsigned cyc;
    logic [7:0]  ch;
    logic [7:0]  dat;
  } exp_t;

  localparam int FRAME = 2048;
  localparam int TOTAL = 2 * FRAME + 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       fp = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic [2:0] bit_delay = 3'd0;
  logic [1:0] chan_delay = 2'd0;
  logic       ser = 1'b0;
  logic       out_valid;
  logic [7:0] out_chan;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int dn = 0;
  int mn = 0;
  int vcnt = 0;
  exp_t q[$];
  string cur_tag = "R1";

  int la_div, la_off, lb_div, lb_off, sw, seed;

  always #2 clk = ~clk;

  serial_stream_rx i_serial_stream_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_16m    (tick),
    .frame_pulse (fp),
    .rate_sel    (rate_sel),
    .bit_delay   (bit_delay),
    .chan_delay  (chan_delay),
    .serial_in   (ser),
    .out_valid   (out_valid),
    .out_chan    (out_chan),
    .out_data    (out_data)
  );

  function automatic logic [7:0] pat(int ch);
    return 8'((ch * 53 + seed) & 255);
  endfunction

  function automatic logic line_bit(int t);
    int div, off, p, b;
    logic [7:0] pb;
    if (t >= sw) begin div = lb_div; off = lb_off; end
    else begin div = la_div; off = la_off; end
    p = (t - off) % FRAME;
    if (p < 0) p += FRAME;
    b  = p / div;
    pb = pat(b / 8);
    return pb[7 - (b % 8)];
  endfunction

  task automatic step();
    @(negedge clk);
    dn++;
  endtask

  // scoreboard: expected bytes of one receive segment
  task automatic push_seg(input int s0, input int d, input int tend, input int base);
    int nch;
    nch = 256 / d;
    for (int k = 0; s0 + (8 * k + 7) * d < tend; k++) begin
      exp_t e;
      e.dat = '0;
      for (int j = 0; j < 8; j++) e.dat[7 - j] = line_bit(s0 + (8 * k + j) * d);
      e.ch  = 8'(k % nch);
      e.cyc = base + 2 * (s0 + (8 * k + 7) * d) + 1;
      q.push_back(e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    mn++;
    if (rst_n && out_valid) begin
      vcnt++;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL %s R1 R4: unexpected byte ch=%0d data=%h cyc=%0d, expected none",
                 cur_tag, out_chan, out_data, mn);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (out_chan !== e.ch || out_data !== e.dat || mn != int'(e.cyc)) begin
          errors++;
          $display("FAIL %s (R3 data/R4 cycle/R5 chan): got ch=%0d data=%h cyc=%0d exp ch=%0d data=%h cyc=%0d",
                   cur_tag, out_chan, out_data, mn, e.ch, e.dat, e.cyc);
        end
      end
    end
  end

  task automatic do_reset();
    step();
    rst_n = 1'b0; tick = 1'b0; fp = 1'b0;
    repeat (4) step();
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    step();
  endtask

  task automatic run_cfg(input string tag, input int ra, input int bda, input int cda,
                         input int ldiv, input bit chg, input int rb, input int bdb,
                         input int cdb);
    int da, offa, db, offb, base;
    cur_tag = tag;
    seed = seed + 17;
    do_reset();
    da   = 8 >> ra;
    offa = (cda * 8 + bda) * da;
    la_div = (ldiv != 0) ? ldiv : da;
    la_off = offa;
    db = 8 >> rb;
    offb = (cdb * 8 + bdb) * db;
    lb_div = db;
    lb_off = offb;
    sw = chg ? (FRAME + offb) : (1 << 30);
    base = dn + 1;
    push_seg(offa, da, chg ? sw : TOTAL, base);
    if (chg) push_seg(sw, db, TOTAL, base);
    for (int t = 0; t < TOTAL; t++) begin
      step();
      if (chg && t >= 1000) begin
        rate_sel = 2'(rb); bit_delay = 3'(bdb); chan_delay = 2'(cdb);
      end else begin
        rate_sel = 2'(ra); bit_delay = 3'(bda); chan_delay = 2'(cda);
      end
      tick = 1'b1;
      fp   = ((t % FRAME) == 0);
      ser  = line_bit(t);
      step();
      tick = 1'b0;
      fp   = 1'b0;
    end
    repeat (10) step();
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s R4 R5: %0d bytes missing, expected 0", tag, q.size());
      q.delete();
    end
  endtask

  initial begin
    seed = 3;
    sw = 1 << 30;
    la_div = 8; la_off = 0; lb_div = 8; lb_off = 0;
    do_reset();
    // R1: ticks and line activity without any frame pulse give no bytes
    begin
      int v0;
      v0 = vcnt;
      for (int t = 0; t < 200; t++) begin
        step(); tick = 1'b1; ser = (t % 3 == 0);
        step(); tick = 1'b0;
      end
      repeat (4) step();
      checks++;
      if (vcnt != v0) begin
        errors++;
        $display("FAIL R1 no frame: got %0d bytes expected 0", vcnt - v0);
      end
    end
    run_cfg("R2 R6",    0, 0, 0, 0, 1'b0, 0, 0, 0);
    run_cfg("R2 4M",    1, 0, 0, 0, 1'b0, 0, 0, 0);
    run_cfg("R2 8M",    2, 0, 0, 0, 1'b0, 0, 0, 0);
    run_cfg("R2 R5",    3, 0, 0, 0, 1'b0, 0, 0, 0);
    run_cfg("R7",       2, 5, 0, 0, 1'b0, 0, 0, 0);
    run_cfg("R8",       1, 0, 3, 0, 1'b0, 0, 0, 0);
    run_cfg("R7 R8 16M",3, 7, 3, 0, 1'b0, 0, 0, 0);
    run_cfg("R7 R8 2M", 0, 7, 2, 0, 1'b0, 0, 0, 0);
    run_cfg("R9",       1, 0, 0, 0, 1'b1, 3, 0, 0);
    run_cfg("R10",      3, 0, 0, 8, 1'b0, 0, 0, 0);
    run_cfg("R11",      2, 0, 0, 0, 1'b1, 2, 3, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule